// File: doc/BRIEF.md
# Clock-Enable Strobe Generator with Selectable Dividers

This block produces two clock-enable strobes for the main system clock domain: an auxiliary enable and a sub-main enable. Each strobe is high for exactly one main-clock cycle per event. Downstream logic stays on the main clock and advances only on cycles where its enable is high. The auxiliary strobe is derived from a slow, free-running external clock that is asynchronous to the main clock. That slow clock is brought into the main domain by a flip-flop synchroniser, and its rising edges become one-cycle pulses.

The sub-main strobe has two possible sources. It can use the same slow-clock pulses, or it can use the fast oscillator that also clocks the main domain. The fast source behaves as a pulse on every cycle. Each strobe has its own divider, selectable as /1, /2, /4 or /8. When a divider setting or the sub-main source changes, that divider restarts, so the next strobe already follows the new setting.

Top module: `clk_enable_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `aux_en` and `sub_en` are low after that edge.
- R2: With `aux_div_sel` = 00 (/1), `aux_en` gives exactly one single-cycle pulse for each rising edge of `slow_clk`, and it is never high on two consecutive cycles.
- R3: `aux_div_sel` codes 01, 10 and 11 divide the slow-clock edge rate by 2, 4 and 8. Over a window holding 24 slow rising edges, `aux_en` gives 12, 6 and 3 pulses respectively.
- R4: With `sub_src_fast` = 0, the sub-main strobe uses slow-clock edges, and `sub_div_sel` codes 00/01/10/11 give 24, 12, 6 and 3 pulses over a window of 24 slow rising edges.
- R5: With `sub_src_fast` = 1 and `sub_div_sel` = 00, `sub_en` is high on every main-clock cycle (600 pulses in 600 cycles).
- R6: With `sub_src_fast` = 1 and `sub_div_sel` = 01, 10 or 11, `sub_en` is high on exactly one cycle in every 2, 4 or 8 (300, 150 or 75 in 600 cycles).
- R7: A change of a divider select restarts that divider. With the fast source and a new ratio N, the first `sub_en` pulse follows the N+1-th rising edge counted from the edge that sees the change.
- R8: A change of `sub_src_fast` also restarts the sub-main divider. After a switch to the fast source with ratio N, the first `sub_en` pulse follows the N+1-th rising edge counted from the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock (fast oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | Slow external clock, asynchronous to `clk` |
| aux_div_sel | input | 2 | Auxiliary divider code: 00 /1, 01 /2, 10 /4, 11 /8 |
| sub_div_sel | input | 2 | Sub-main divider code, same encoding |
| sub_src_fast | input | 1 | Sub-main source: 0 slow clock edges, 1 fast clock |
| aux_en | output | 1 | Auxiliary single-cycle enable strobe |
| sub_en | output | 1 | Sub-main single-cycle enable strobe |

## Verification
The slow clock runs at 30 main cycles per period with a phase offset, so its edges never coincide with main-clock edges. Windows of exactly 24 slow periods give pulse counts that do not depend on where the divider phase starts. Under that pattern, each of the four ratios produces a distinct count, and a wrong code decode or a broken edge detector shows up as a different number. The fast-source runs separate an every-cycle source from a decimated one. Timed select and source switches measure the latency to the first strobe, which shows whether the divider really restarts or keeps counting from a stale value.

// File: rtl/cen_pkg.sv
// Shared types and helpers for the clock-enable generator.
// Assumes divider ratios are powers of two up to 2**CEN_MAX_LOG2.
package cen_pkg;

    localparam int CEN_MAX_LOG2 = 3;
    localparam int CEN_SEL_W    = $clog2(CEN_MAX_LOG2 + 1);
    localparam int CEN_CNT_W    = CEN_MAX_LOG2;

    typedef enum logic [CEN_SEL_W-1:0] {
        DIV_BY_1 = 2'd0,
        DIV_BY_2 = 2'd1,
        DIV_BY_4 = 2'd2,
        DIV_BY_8 = 2'd3
    } div_code_e;

    // Terminal count for a divider code: ratio minus one.
    function automatic logic [CEN_CNT_W-1:0] div_last(input div_code_e code);
        logic [CEN_CNT_W-1:0] m;
        m = '0;
        for (int i = 0; i < CEN_CNT_W; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cen_sync_edge.sv
// Brings an asynchronous slow clock into the main domain through a
// flip-flop chain and emits a one-cycle pulse on each rising edge of
// the synchronised signal. Assumes the slow clock is high and low for
// at least two main-clock cycles each.
module cen_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the async level through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // Rising edge: newest synchronised level high, previous level low.
    always_comb begin
        rise_pulse = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/cen_divider.sv
// Power-of-two pulse divider. It counts source pulses and emits a
// registered one-cycle strobe on every ratio-th pulse. A change of the
// select code or a restart request clears the count, and no strobe is
// issued in that cycle.
module cen_divider
    import cen_pkg::*;
#(
    parameter int CNT_W = CEN_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pulse_in,
    input  logic [CEN_SEL_W-1:0] div_sel,
    input  logic                 restart_in,
    output logic                 en_out
);

    div_code_e        sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;
    logic             reconfig;
    logic             en_q;

    // Terminal count of the active code, and detection of a new setting.
    always_comb begin
        last_val = CNT_W'(div_last(sel_q));
        reconfig = (div_sel != sel_q) || restart_in;
    end

    // Count source pulses, strobe on wrap, restart on reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= DIV_BY_1;
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (reconfig) begin
            sel_q <= div_code_e'(div_sel);
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (pulse_in) begin
            en_q  <= (cnt_q == last_val);
            cnt_q <= (cnt_q == last_val) ? '0 : cnt_q + 1'b1;
        end else begin
            en_q  <= 1'b0;
        end
    end

    assign en_out = en_q;

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |=> !en_out);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == DIV_BY_1 && !reconfig && pulse_in) |=> en_out);

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_val);

endmodule

// File: rtl/clk_enable_gen.sv
// Top of the clock-enable generator. Derives an auxiliary strobe from
// the slow external clock, and a sub-main strobe from either that clock
// or the fast main clock. Each strobe has its own selectable divider.
// Assumes clk is the fast oscillator and slow_clk is asynchronous.
module clk_enable_gen
    import cen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_clk,
    input  logic [CEN_SEL_W-1:0] aux_div_sel,
    input  logic [CEN_SEL_W-1:0] sub_div_sel,
    input  logic                 sub_src_fast,
    output logic                 aux_en,
    output logic                 sub_en
);

    localparam int NUM_DIV = 2;

    logic                 slow_pulse;
    logic                 src_q;
    logic                 src_change;
    logic [NUM_DIV-1:0]   div_pulse;
    logic [NUM_DIV-1:0]   div_restart;
    logic [CEN_SEL_W-1:0] div_code [NUM_DIV];
    logic [NUM_DIV-1:0]   div_en;

    cen_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (slow_clk),
        .rise_pulse (slow_pulse)
    );

    // Hold the active sub-main source so that a switch can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= sub_src_fast;
    end

    // Route the source pulses, restarts and codes to each divider.
    always_comb begin
        src_change     = (sub_src_fast != src_q);
        div_pulse[0]   = slow_pulse;
        div_restart[0] = 1'b0;
        div_code[0]    = aux_div_sel;
        div_pulse[1]   = src_q ? 1'b1 : slow_pulse;
        div_restart[1] = src_change;
        div_code[1]    = sub_div_sel;
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        cen_divider #(.CNT_W(CEN_CNT_W)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .pulse_in   (div_pulse[g]),
            .div_sel    (div_code[g]),
            .restart_in (div_restart[g]),
            .en_out     (div_en[g])
        );
    end

    assign aux_en = div_en[0];
    assign sub_en = div_en[1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!aux_en && !sub_en));

    // R8
    src_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_change |=> !sub_en);

    // R2
    aux_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_en |=> !aux_en);

endmodule

// File: tb/tb_clk_enable_gen.sv
module tb_clk_enable_gen;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_HALF  = 150;
    localparam int SLOW_WIN   = 720;
    localparam int FAST_WIN   = 600;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_clk = 1'b0;
    logic [1:0] aux_div_sel = 2'b00;
    logic [1:0] sub_div_sel = 2'b00;
    logic       sub_src_fast = 1'b0;
    logic       aux_en;
    logic       sub_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    clk_enable_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_clk     (slow_clk),
        .aux_div_sel  (aux_div_sel),
        .sub_div_sel  (sub_div_sel),
        .sub_src_fast (sub_src_fast),
        .aux_en       (aux_en),
        .sub_en       (sub_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #3;
        forever #SLOW_HALF slow_clk = ~slow_clk;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
        end
    endtask

    // Count strobes over n cycles, sampled at falling edges.
    task automatic window(input int n, output int na, output int ns, output int dbl_a);
        bit pa;
        na = 0; ns = 0; dbl_a = 0; pa = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (aux_en) na++;
            if (sub_en) ns++;
            if (aux_en && pa) dbl_a++;
            pa = aux_en;
        end
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    // R1: enables low during reset.
    task automatic t_reset();
        int bad;
        bad = 0;
        @(negedge clk);
        rst_n = 1'b0;
        sub_src_fast = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (aux_en || sub_en) bad++;
        end
        chk("R1 enables during reset", bad, 0);
        chk("R1 sub_en level in reset", int'(sub_en), 0);
        sub_src_fast = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2/R3: auxiliary strobe at all ratios.
    task automatic t_aux();
        int na, ns, d;
        int exp_cnt [4] = '{24, 12, 6, 3};
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            aux_div_sel = 2'(c);
            settle();
            window(SLOW_WIN, na, ns, d);
            if (c == 0) begin
                chk("R2 aux /1 pulses", na, 24);
                chk("R2 aux no double cycle", d, 0);
            end else begin
                chk($sformatf("R3 aux code %0d pulses", c), na, exp_cnt[c]);
            end
        end
    endtask

    // R4: sub-main from slow edges.
    task automatic t_sub_slow();
        int na, ns, d;
        int exp_cnt [4] = '{24, 12, 6, 3};
        @(negedge clk);
        sub_src_fast = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            sub_div_sel = 2'(c);
            settle();
            window(SLOW_WIN, na, ns, d);
            chk($sformatf("R4 sub slow code %0d pulses", c), ns, exp_cnt[c]);
        end
    endtask

    // R5/R6: sub-main from fast clock.
    task automatic t_sub_fast();
        int na, ns, d;
        int exp_cnt [4] = '{600, 300, 150, 75};
        @(negedge clk);
        sub_src_fast = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            sub_div_sel = 2'(c);
            settle();
            window(FAST_WIN, na, ns, d);
            if (c == 0) chk("R5 sub fast /1 pulses", ns, exp_cnt[c]);
            else        chk($sformatf("R6 sub fast code %0d pulses", c), ns, exp_cnt[c]);
        end
    endtask

    // R7: select change restarts divider (fast /8 -> /4 gives 5 edges).
    task automatic t_sel_restart();
        int n;
        @(negedge clk);
        sub_src_fast = 1'b1;
        sub_div_sel = 2'b11;
        settle();
        repeat (3) @(negedge clk);
        sub_div_sel = 2'b10;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (sub_en) break;
        end
        chk("R7 edges to first strobe after /8->/4", n, 5);
    endtask

    // R8: source switch slow->fast at /2 restarts divider (3 edges).
    task automatic t_src_restart();
        int n;
        @(negedge clk);
        sub_src_fast = 1'b0;
        sub_div_sel = 2'b01;
        settle();
        sub_src_fast = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (sub_en) break;
        end
        chk("R8 edges to first strobe after source switch", n, 3);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 aux_en after reset edges", int'(aux_en), 0);
        chk("R1 sub_en after reset edges", int'(sub_en), 0);
        rst_n = 1'b1;
        t_aux();
        t_sub_slow();
        t_sub_fast();
        t_sel_restart();
        t_src_restart();
        t_reset();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule